// File: doc/BRIEF.md
# Predicate Register File With Complementary Writes

This block holds a bank of one-bit predicates that guard instruction execution. Two combinational read ports return the guard predicate and a source predicate for the instructions being issued. There are no condition flags anywhere else: predicates change only through compare-result write lanes. Each lane updates a pair of destinations in one cycle, normally with the condition on one and its inverse on the other.

Each write lane carries a mode, a qualifying predicate index, two target indices and the one-bit compare outcome. The qualifying predicate is looked up inside the block from the stored state. The mode then decides whether the pair is written, cleared or set. Predicate 0 is a constant true: any half of a write aimed at it is dropped. The parallel-AND and parallel-OR modes only ever move a bit in one direction, so several lanes can target the same predicate in one cycle without conflict.

Top module: `pred_file`

## Requirements
- R1: The file holds NUM_PRED (default 64) predicates, indexed 0 to NUM_PRED-1. After reset, every predicate other than index 0 reads 0 on both read ports.
- R2: Predicate 0 always reads 1 on every read port. A write half that targets index 0 is discarded, and the other half of the same write still applies.
- R3: Mode 2'b00 (normal), with the qualifying predicate true: target A takes the compare result and target B takes its inverse.
- R4: Mode 2'b00 (normal), with the qualifying predicate false: neither target changes.
- R5: Mode 2'b01 (unconditional): with the qualifying predicate false, both targets are cleared to 0. With it true, the lane behaves as in R3.
- R6: Mode 2'b10 (AND): with the qualifying predicate true and the result 0, both targets are cleared. In every other case neither target changes.
- R7: Mode 2'b11 (OR): with the qualifying predicate true and the result 1, both targets are set. In every other case neither target changes.
- R8: When both targets of one lane name the same predicate, the value meant for target A is the one stored.
- R9: When several lanes write the same predicate in one cycle, the lane with the highest index wins. AND lanes that all clear, or OR lanes that all set, combine to the same single value.
- R10: A read, and the qualifying-predicate lookup, made in the same cycle as a write see the old value. The new value is visible from the next cycle on. A predicate that no lane writes keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_idx | input | NUM_RD*IDXW | Read indices; port r uses bits [r*IDXW +: IDXW] |
| rd_val | output | NUM_RD | Read data, one bit per read port |
| wr_en | input | NUM_WR | Lane valid, one bit per write lane |
| wr_mode | input | 2*NUM_WR | Lane mode; lane w uses bits [2w +: 2] (00 normal, 01 unconditional, 10 AND, 11 OR) |
| wr_qp | input | NUM_WR*IDXW | Qualifying predicate index per lane |
| wr_tgt_a | input | NUM_WR*IDXW | Target A index per lane (gets the result) |
| wr_tgt_b | input | NUM_WR*IDXW | Target B index per lane (gets the inverse in normal mode) |
| wr_res | input | NUM_WR | Compare outcome, one bit per lane |

## Verification
A wrong stored bit stays invisible until some read port or qualifying lookup selects that index. The bench therefore reads random indices every cycle and sweeps the whole file after reset, so a corrupted bit shows up within a few cycles of being written. A mistake in a lane's mode decode appears on the read port one cycle after the write. When the bad bit is later used as a qualifier, it also spreads into wrong writes to other predicates. A same-cycle read that returned the new value would break the old-value checks at once, so bypass mistakes are caught in the cycle of the write itself.

// File: rtl/pred_pkg.sv
package pred_pkg;

  typedef enum logic [1:0] {
    CMP_NORM = 2'b00,
    CMP_UNC  = 2'b01,
    CMP_AND  = 2'b10,
    CMP_OR   = 2'b11
  } cmp_mode_e;

  // hit: the pair is written; va/vb: values for target A and target B
  typedef struct packed {
    logic hit;
    logic va;
    logic vb;
  } pair_eff_t;

  function automatic pair_eff_t pair_effect(cmp_mode_e m, logic q, logic r);
    pair_eff_t e;
    e = '0;
    case (m)
      CMP_NORM: begin e.hit = q;       e.va = r;     e.vb = ~r;     end
      CMP_UNC:  begin e.hit = 1'b1;    e.va = q & r; e.vb = q & ~r; end
      CMP_AND:  begin e.hit = q & ~r;  e.va = 1'b0;  e.vb = 1'b0;   end
      CMP_OR:   begin e.hit = q & r;   e.va = 1'b1;  e.vb = 1'b1;   end
      default:  e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pred_rd_port.sv
module pred_rd_port #(
  parameter int NUM_PRED = 64,
  parameter int IDXW     = $clog2(NUM_PRED)
) (
  input  logic [NUM_PRED-1:0] state,
  input  logic [IDXW-1:0]     idx,
  output logic                val
);
  assign val = state[idx];
endmodule

// File: rtl/pred_lane.sv
module pred_lane
  import pred_pkg::*;
#(
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      mode,
  input  logic            q,
  input  logic            res,
  input  logic [IDXW-1:0] a_idx,
  input  logic [IDXW-1:0] b_idx,
  output logic            a_wr,
  output logic            a_val,
  output logic            b_wr,
  output logic            b_val
);
  cmp_mode_e m;
  pair_eff_t eff;

  assign m     = cmp_mode_e'(mode);
  assign eff   = pair_effect(m, q, res);
  assign a_wr  = en & eff.hit & (a_idx != '0);
  assign b_wr  = en & eff.hit & (b_idx != '0);
  assign a_val = eff.va;
  assign b_val = eff.vb;

  AST_NORM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && m == CMP_NORM && !q) |-> (!a_wr && !b_wr)); // R4
  AST_NORM_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && m == CMP_NORM && a_wr && b_wr) |-> (a_val != b_val && a_val == res)); // R3
  AST_UNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && m == CMP_UNC && !q && a_idx != '0) |-> (a_wr && !a_val && !b_val)); // R5
  AST_AND_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && m == CMP_AND && (a_wr || b_wr)) |-> (!a_val && !b_val && !res && q)); // R6
  AST_OR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && m == CMP_OR && (a_wr || b_wr)) |-> (a_val && b_val && res && q)); // R7
  AST_NO_P0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr |-> a_idx != '0) and (b_wr |-> b_idx != '0)); // R2
endmodule

// File: rtl/pred_store.sv
module pred_store #(
  parameter int NUM_PRED = 64,
  parameter int NUM_WR   = 2,
  parameter int IDXW     = $clog2(NUM_PRED)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_WR-1:0]      a_wr,
  input  logic [NUM_WR*IDXW-1:0] a_idx,
  input  logic [NUM_WR-1:0]      a_val,
  input  logic [NUM_WR-1:0]      b_wr,
  input  logic [NUM_WR*IDXW-1:0] b_idx,
  input  logic [NUM_WR-1:0]      b_val,
  output logic [NUM_PRED-1:0]    state
);
  logic [NUM_PRED-1:0] nxt;
  logic [NUM_PRED-1:0] wr_hit;

  // Lanes in ascending order, B before A within a lane: A beats B, higher lane beats lower
  always_comb begin
    nxt    = state;
    wr_hit = '0;
    for (int w = 0; w < NUM_WR; w++) begin
      if (b_wr[w]) begin
        nxt[b_idx[w*IDXW +: IDXW]]    = b_val[w];
        wr_hit[b_idx[w*IDXW +: IDXW]] = 1'b1;
      end
      if (a_wr[w]) begin
        nxt[a_idx[w*IDXW +: IDXW]]    = a_val[w];
        wr_hit[a_idx[w*IDXW +: IDXW]] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_PRED; i++) begin : g_bit
    if (i == 0) begin : g_const
      assign state[i] = 1'b1;
    end else begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state[i] <= 1'b0;
        else        state[i] <= nxt[i];
      end
      AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit[i] |=> state[i] == $past(state[i])); // R10
    end
  end
endmodule

// File: rtl/pred_file.sv
module pred_file
  import pred_pkg::*;
#(
  parameter int NUM_PRED = 64,
  parameter int NUM_RD   = 2,
  parameter int NUM_WR   = 2,
  parameter int IDXW     = $clog2(NUM_PRED)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_RD*IDXW-1:0] rd_idx,
  output logic [NUM_RD-1:0]      rd_val,
  input  logic [NUM_WR-1:0]      wr_en,
  input  logic [2*NUM_WR-1:0]    wr_mode,
  input  logic [NUM_WR*IDXW-1:0] wr_qp,
  input  logic [NUM_WR*IDXW-1:0] wr_tgt_a,
  input  logic [NUM_WR*IDXW-1:0] wr_tgt_b,
  input  logic [NUM_WR-1:0]      wr_res
);
  logic [NUM_PRED-1:0] state;
  logic [NUM_WR-1:0]   qp_val;
  logic [NUM_WR-1:0]   a_wr, a_val, b_wr, b_val;

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    pred_rd_port #(.NUM_PRED(NUM_PRED), .IDXW(IDXW)) u_rd (
      .state(state), .idx(rd_idx[r*IDXW +: IDXW]), .val(rd_val[r]));
    AST_P0_READS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx[r*IDXW +: IDXW] == '0) |-> rd_val[r]); // R2
  end

  for (genvar w = 0; w < NUM_WR; w++) begin : g_lane
    pred_rd_port #(.NUM_PRED(NUM_PRED), .IDXW(IDXW)) u_qp (
      .state(state), .idx(wr_qp[w*IDXW +: IDXW]), .val(qp_val[w]));
    pred_lane #(.IDXW(IDXW)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(wr_en[w]), .mode(wr_mode[2*w +: 2]),
      .q(qp_val[w]), .res(wr_res[w]),
      .a_idx(wr_tgt_a[w*IDXW +: IDXW]), .b_idx(wr_tgt_b[w*IDXW +: IDXW]),
      .a_wr(a_wr[w]), .a_val(a_val[w]), .b_wr(b_wr[w]), .b_val(b_val[w]));
  end

  pred_store #(.NUM_PRED(NUM_PRED), .NUM_WR(NUM_WR), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_idx(wr_tgt_a), .a_val(a_val),
    .b_wr(b_wr), .b_idx(wr_tgt_b), .b_val(b_val),
    .state(state));
endmodule

// File: tb/pred_file_tb.sv
module pred_file_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;
  localparam int NR = 2;
  localparam int NW = 2;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR*IW-1:0] rd_idx = '0;
  logic [NR-1:0]    rd_val;
  logic [NW-1:0]    wr_en = '0;
  logic [2*NW-1:0]  wr_mode = '0;
  logic [NW*IW-1:0] wr_qp = '0, wr_tgt_a = '0, wr_tgt_b = '0;
  logic [NW-1:0]    wr_res = '0;

  logic [NP-1:0] model;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_file u_dut (.clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_val(rd_val),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_qp(wr_qp), .wr_tgt_a(wr_tgt_a),
    .wr_tgt_b(wr_tgt_b), .wr_res(wr_res));

  // Reference: one lane at a time, later lanes override, A stored after B
  function automatic logic [NP-1:0] model_next(logic [NP-1:0] old);
    logic [NP-1:0] n = old;
    for (int w = 0; w < NW; w++) begin
      int qi = int'(wr_qp[w*IW +: IW]);
      int ai = int'(wr_tgt_a[w*IW +: IW]);
      int bi = int'(wr_tgt_b[w*IW +: IW]);
      logic q = (qi == 0) ? 1'b1 : old[qi];
      logic r = wr_res[w];
      logic go = 1'b0, va = 1'b0, vb = 1'b0;
      if (wr_en[w]) begin
        case (wr_mode[2*w +: 2])
          2'b00: if (q) begin go = 1; va = r; vb = !r; end
          2'b01: begin go = 1; if (q) begin va = r; vb = !r; end end
          2'b10: if (q && !r) go = 1;
          default: if (q && r) begin go = 1; va = 1; vb = 1; end
        endcase
      end
      if (go) begin
        if (bi != 0) n[bi] = vb;
        if (ai != 0) n[ai] = va;
      end
    end
    n[0] = 1'b1;
    return n;
  endfunction

  task automatic set_lane(int w, logic [1:0] m, int qp, int a, int b, logic r);
    wr_en[w] = 1'b1;
    wr_mode[2*w +: 2] = m;
    wr_qp[w*IW +: IW] = IW'(qp);
    wr_tgt_a[w*IW +: IW] = IW'(a);
    wr_tgt_b[w*IW +: IW] = IW'(b);
    wr_res[w] = r;
  endtask

  // Called at a negedge with lanes set; returns at the next negedge with lanes idle
  task automatic step();
    @(posedge clk);
    #1 model = model_next(model);
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic rd_chk(int p, int idx, logic exp, string tag);
    rd_idx[p*IW +: IW] = IW'(idx);
    #1;
    n_chk++;
    if (rd_val[p] !== exp) begin
      n_fail++;
      $display("FAIL %s: port %0d idx %0d actual %b expected %b", tag, p, idx, rd_val[p], exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    model = '0;
    model[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 predicate 0 on both ports
    for (int i = 0; i < NP; i++) begin
      rd_chk(0, i, (i == 0), "R1 reset");
      rd_chk(1, i, (i == 0), "R1 reset");
    end

    // R3 normal, qualifier p0
    set_lane(0, 2'b00, 0, 5, 6, 1'b1);
    step();
    rd_chk(0, 5, 1'b1, "R3 normal A");
    rd_chk(1, 6, 1'b0, "R3 normal B");

    // R4 normal, false qualifier (6 is 0): suppressed
    set_lane(0, 2'b00, 6, 5, 7, 1'b0);
    step();
    rd_chk(0, 5, 1'b1, "R4 suppressed A");
    rd_chk(1, 7, 1'b0, "R4 suppressed B");

    // R5 unconditional with false qualifier clears both
    set_lane(0, 2'b00, 0, 8, 9, 1'b1);   // 8=1, 9=0
    step();
    set_lane(0, 2'b01, 6, 5, 8, 1'b1);
    step();
    rd_chk(0, 5, 1'b0, "R5 unc clear A");
    rd_chk(1, 8, 1'b0, "R5 unc clear B");
    set_lane(0, 2'b01, 0, 5, 8, 1'b0);   // true qualifier: like normal
    step();
    rd_chk(0, 5, 1'b0, "R5 unc normal A");
    rd_chk(1, 8, 1'b1, "R5 unc normal B");

    // R7 OR on two lanes, overlapping target 20; R9
    set_lane(0, 2'b11, 0, 20, 21, 1'b1);
    set_lane(1, 2'b11, 0, 20, 22, 1'b1);
    step();
    rd_chk(0, 20, 1'b1, "R7 OR shared");
    rd_chk(1, 22, 1'b1, "R9 OR second lane");
    set_lane(0, 2'b11, 0, 23, 24, 1'b0); // OR with false result: no change
    step();
    rd_chk(0, 23, 1'b0, "R7 OR no-op");

    // R6 AND on two lanes, both clear 20
    set_lane(0, 2'b10, 0, 20, 21, 1'b0);
    set_lane(1, 2'b10, 0, 20, 25, 1'b0);
    step();
    rd_chk(0, 20, 1'b0, "R6 AND clear");
    rd_chk(1, 22, 1'b1, "R6 AND untouched");
    set_lane(0, 2'b10, 0, 22, 21, 1'b1); // AND with true result: no change
    step();
    rd_chk(0, 22, 1'b1, "R6 AND no-op");

    // R8 same target: A value wins
    set_lane(0, 2'b00, 0, 30, 30, 1'b1);
    step();
    rd_chk(0, 30, 1'b1, "R8 same target res1");
    set_lane(0, 2'b00, 0, 30, 30, 1'b0);
    step();
    rd_chk(0, 30, 1'b0, "R8 same target res0");

    // R2 target 0 drops only its half
    set_lane(0, 2'b00, 0, 0, 31, 1'b0);
    step();
    rd_chk(0, 0, 1'b1, "R2 p0 write ignored");
    rd_chk(1, 31, 1'b1, "R2 other half kept");
    set_lane(0, 2'b10, 0, 0, 0, 1'b0);
    step();
    rd_chk(0, 0, 1'b1, "R2 p0 AND ignored");

    // R9 two normal lanes on same predicate: higher lane wins
    set_lane(0, 2'b00, 0, 40, 41, 1'b1);
    set_lane(1, 2'b00, 0, 40, 42, 1'b0);
    step();
    rd_chk(0, 40, 1'b0, "R9 lane priority");

    // R10 same-cycle read returns old value
    set_lane(0, 2'b00, 0, 44, 45, 1'b1);
    rd_chk(0, 44, 1'b0, "R10 old value same cycle");
    step();
    rd_chk(0, 44, 1'b1, "R10 new value next cycle");

    // Random traffic against the model, restricted index range for collisions
    for (int c = 0; c < 2000; c++) begin
      for (int w = 0; w < NW; w++) begin
        if ($urandom_range(0, 3) != 0)
          set_lane(w, 2'($urandom_range(0, 3)), $urandom_range(0, 15),
                   $urandom_range(0, 15), $urandom_range(0, 15), 1'($urandom_range(0, 1)));
      end
      for (int p = 0; p < NR; p++) begin
        int ix = $urandom_range(0, 15);
        rd_chk(p, ix, model[ix], "R9 R10 random");
      end
      step();
    end

    // Final sweep of the whole file
    for (int i = 0; i < NP; i++) rd_chk(0, i, model[i], "R1 final sweep");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule